// File: doc/BRIEF.md
# Messaging Unit Inbound Interrupt Status Register

This block holds the inbound interrupt status word of a host-bridge messaging unit. It takes single-cycle event pulses from the two inbound message registers and from the inbound post queue, where one pulse marks one message frame address posted from the PCI side. It also watches the head pointer, tail pointer and full flag of two circular queues, the inbound post queue and the outbound free queue. It reads the current contents of the inbound doorbell register. Events and overflows are captured as sticky flags, and software clears each one by writing 1 to its bit. The doorbell-derived bits are live read-only levels.

Two outputs leave the block. `mchk_o` is the machine-check request: it is high while a queue-overflow flag is set or while the top doorbell bit is set. `irq_o` is the ordinary interrupt request, high while any other status bit is set. Software reaches the 32-bit status word as two 16-bit halves through a small read/write port. The read path is combinational from the half-select input.

Top module: `msgu_irq_status`

## Requirements
- R1: After reset both halves read 0x0000. With the doorbell input at zero, `irq_o` and `mchk_o` are low.
- R2: The high half (`reg_hi_i`=1) always reads 0x0000. In the low half, bits 15–9, 6 and 2 always read 0. Writes to any of these bits, and any write to the high half, change nothing.
- R3: Bit 7 (inbound post overflow) sets in the cycle after the inbound post queue's condition becomes true. The condition is head equal to tail while the full flag is high. Writing 1 to bit 7 of the low half clears it.
- R4: Bit 8 (outbound free overflow) behaves the same way on the outbound free queue's pointers and full flag. Writing 1 to bit 8 clears it.
- R5: `mchk_o` is high whenever bit 7 or bit 8 is set, or doorbell bit 31 is high.
- R6: A pulse on `post_evt_i` sets bit 5 at the next clock. Writing 1 to bit 5 clears it.
- R7: Bit 4 always equals doorbell bit 31 and ignores writes.
- R8: Bit 3 is high exactly when any of doorbell bits 30–0 is high, and ignores writes.
- R9: Pulses on `msg0_evt_i` and `msg1_evt_i` set bits 0 and 1 respectively. Each bit is cleared by writing 1 to it, independently of the other bit.
- R10: If a set event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R11: `irq_o` is high exactly when bit 5, 3, 1 or 0 reads 1.
- R12: An overflow flag sets only when its condition begins. Clearing it while the queue stays at head equal to tail and full leaves it clear until the condition ends and occurs again.
- R13: Writing 0 to a sticky bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg0_evt_i | input | 1 | Inbound message register 0 event pulse |
| msg1_evt_i | input | 1 | Inbound message register 1 event pulse |
| post_evt_i | input | 1 | Frame address posted to inbound post queue |
| ipq_head_i | input | PTR_W | Inbound post queue head pointer |
| ipq_tail_i | input | PTR_W | Inbound post queue tail pointer |
| ipq_full_i | input | 1 | Inbound post queue full |
| ofq_head_i | input | PTR_W | Outbound free queue head pointer |
| ofq_tail_i | input | PTR_W | Outbound free queue tail pointer |
| ofq_full_i | input | 1 | Outbound free queue full |
| doorbell_i | input | DB_W | Current inbound doorbell register contents |
| reg_hi_i | input | 1 | Half select: 1 = bits 31–16, 0 = bits 15–0 |
| reg_wr_i | input | 1 | Write strobe for the selected half |
| reg_wdata_i | input | HALF_W | Write data (1 clears a sticky bit) |
| reg_rdata_o | output | HALF_W | Read data of the selected half |
| irq_o | output | 1 | Ordinary interrupt request |
| mchk_o | output | 1 | Machine-check request |

## Verification
The assertions assume that event inputs and write strobes are sampled at rising edges. They also assume the inputs are steady across each edge, so that a set or a clear seen by the checker is one the flag register also saw. The bench changes every input only at falling edges and holds it for a whole cycle. Event pulses last exactly one cycle. Queue pointers and full flags stay quiet during reset, so that no overflow onset overlaps the release of reset.

// File: rtl/msgu_irq_pkg.sv
package msgu_irq_pkg;
  localparam int HALF_W = 16;
  localparam int NFLAG  = 5;

  // sticky flag slots
  localparam int FL_MSG0 = 0;
  localparam int FL_MSG1 = 1;
  localparam int FL_POST = 2;
  localparam int FL_IPOV = 3;
  localparam int FL_OFOV = 4;

  // bit positions in the low half of the status word
  localparam int BIT_MSG0 = 0;
  localparam int BIT_MSG1 = 1;
  localparam int BIT_DBEL = 3;
  localparam int BIT_MCHK = 4;
  localparam int BIT_POST = 5;
  localparam int BIT_IPOV = 7;
  localparam int BIT_OFOV = 8;

  function automatic int flag_bit(input int slot);
    case (slot)
      FL_MSG0: flag_bit = BIT_MSG0;
      FL_MSG1: flag_bit = BIT_MSG1;
      FL_POST: flag_bit = BIT_POST;
      FL_IPOV: flag_bit = BIT_IPOV;
      default: flag_bit = BIT_OFOV;
    endcase
  endfunction
endpackage

// File: rtl/msgu_rst_sync.sv
module msgu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/msgu_ovf_detect.sv
module msgu_ovf_detect #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] head_i,
  input  logic [PTR_W-1:0] tail_i,
  input  logic             full_i,
  output logic             onset_o
);
  logic cond;
  logic cond_q;
  logic cond_d;

  assign cond = full_i && (head_i == tail_i);

  always_comb begin
    cond_d = cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond_d;
  end

  assign onset_o = cond & ~cond_q;
endmodule

// File: rtl/msgu_w1c_bank.sv
module msgu_w1c_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic en;
    logic nxt;

    always_comb begin
      en  = set_i[i] | clr_i[i];
      nxt = set_i[i] | (flag_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[i] <= 1'b0;
      else if (en) flag_q[i] <= nxt;
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/msgu_irq_status.sv
module msgu_irq_status
  import msgu_irq_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int DB_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg0_evt_i,
  input  logic              msg1_evt_i,
  input  logic              post_evt_i,
  input  logic [PTR_W-1:0]  ipq_head_i,
  input  logic [PTR_W-1:0]  ipq_tail_i,
  input  logic              ipq_full_i,
  input  logic [PTR_W-1:0]  ofq_head_i,
  input  logic [PTR_W-1:0]  ofq_tail_i,
  input  logic              ofq_full_i,
  input  logic [DB_W-1:0]   doorbell_i,
  input  logic              reg_hi_i,
  input  logic              reg_wr_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  output logic [HALF_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              mchk_o
);
  localparam int NQ      = 2;
  localparam int DB_MC   = DB_W - 1;

  logic             rst_sync_n;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flags_q;
  logic [NQ-1:0]    ovf_onset;
  logic             wr_lo;
  logic             db_pend;
  logic             db_mchk;
  logic [HALF_W-1:0] rd_lo;
  logic             unused_wdata;

  logic [PTR_W-1:0] q_head [NQ];
  logic [PTR_W-1:0] q_tail [NQ];
  logic [NQ-1:0]    q_full;

  msgu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign q_head[0] = ipq_head_i;
  assign q_tail[0] = ipq_tail_i;
  assign q_full[0] = ipq_full_i;
  assign q_head[1] = ofq_head_i;
  assign q_tail[1] = ofq_tail_i;
  assign q_full[1] = ofq_full_i;

  for (genvar q = 0; q < NQ; q++) begin : g_ovf
    msgu_ovf_detect #(.PTR_W(PTR_W)) u_det (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .head_i  (q_head[q]),
      .tail_i  (q_tail[q]),
      .full_i  (q_full[q]),
      .onset_o (ovf_onset[q])
    );
  end

  always_comb begin
    set_vec          = '0;
    set_vec[FL_MSG0] = msg0_evt_i;
    set_vec[FL_MSG1] = msg1_evt_i;
    set_vec[FL_POST] = post_evt_i;
    set_vec[FL_IPOV] = ovf_onset[0];
    set_vec[FL_OFOV] = ovf_onset[1];
  end

  assign wr_lo = reg_wr_i & ~reg_hi_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_clr
    localparam int FB = flag_bit(i);
    assign clr_vec[i] = wr_lo & reg_wdata_i[FB];
  end

  assign unused_wdata = ^reg_wdata_i;

  msgu_w1c_bank #(.N(NFLAG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags_q)
  );

  assign db_pend = |doorbell_i[DB_MC-1:0];
  assign db_mchk = doorbell_i[DB_MC];

  always_comb begin
    rd_lo           = '0;
    rd_lo[BIT_MSG0] = flags_q[FL_MSG0];
    rd_lo[BIT_MSG1] = flags_q[FL_MSG1];
    rd_lo[BIT_DBEL] = db_pend;
    rd_lo[BIT_MCHK] = db_mchk;
    rd_lo[BIT_POST] = flags_q[FL_POST];
    rd_lo[BIT_IPOV] = flags_q[FL_IPOV];
    rd_lo[BIT_OFOV] = flags_q[FL_OFOV];
    reg_rdata_o     = reg_hi_i ? '0 : rd_lo;
  end

  assign mchk_o = flags_q[FL_IPOV] | flags_q[FL_OFOV] | db_mchk;
  assign irq_o  = flags_q[FL_MSG0] | flags_q[FL_MSG1] | flags_q[FL_POST] | db_pend;
endmodule

// File: rtl/msgu_irq_status_chk.sv
module msgu_irq_status_chk
  import msgu_irq_pkg::*;
#(
  parameter int DB_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  set_vec,
  input logic [NFLAG-1:0]  clr_vec,
  input logic [DB_W-1:0]   doorbell,
  input logic              rd_hi,
  input logic [HALF_W-1:0] rdata,
  input logic              irq,
  input logic              mchk
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_fl
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
    // covers the write-1 clear of R3, R4, R6 and R9
    assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flags[i]));
  end

  assert_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |-> (rdata == '0));
  assert_rsvd_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |-> (rdata[15:9] == '0 && !rdata[6] && !rdata[2]));
  assert_db_mchk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell[DB_W-1] |-> mchk);
  assert_ovf_mchk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_IPOV] || flags[FL_OFOV]) |-> mchk);
  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |-> (rdata[BIT_MCHK] == doorbell[DB_W-1]));
  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_MSG0] || flags[FL_MSG1] || flags[FL_POST]) |-> irq);
endmodule

bind msgu_irq_status msgu_irq_status_chk #(.DB_W(DB_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .flags    (flags_q),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .doorbell (doorbell_i),
  .rd_hi    (reg_hi_i),
  .rdata    (reg_rdata_o),
  .irq      (irq_o),
  .mchk     (mchk_o)
);

// File: tb/msgu_irq_status_tb_top.sv
module msgu_irq_status_tb_top;
  localparam int PTR_W = 6;
  localparam int DB_W  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic msg0_evt, msg1_evt, post_evt;
  logic [PTR_W-1:0] ipq_head, ipq_tail, ofq_head, ofq_tail;
  logic ipq_full, ofq_full;
  logic [DB_W-1:0] doorbell;
  logic reg_hi, reg_wr;
  logic [15:0] reg_wdata, reg_rdata;
  logic irq, mchk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msgu_irq_status #(.PTR_W(PTR_W), .DB_W(DB_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg0_evt_i(msg0_evt), .msg1_evt_i(msg1_evt), .post_evt_i(post_evt),
    .ipq_head_i(ipq_head), .ipq_tail_i(ipq_tail), .ipq_full_i(ipq_full),
    .ofq_head_i(ofq_head), .ofq_tail_i(ofq_tail), .ofq_full_i(ofq_full),
    .doorbell_i(doorbell), .reg_hi_i(reg_hi), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .mchk_o(mchk)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic hi, output logic [15:0] v);
    reg_hi = hi;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_lo(input logic [15:0] d);
    @(negedge clk);
    reg_hi = 1'b0; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr_hi(input logic [15:0] d);
    @(negedge clk);
    reg_hi = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; reg_hi = 1'b0;
  endtask

  task automatic pulse(input logic m0, input logic m1, input logic p);
    @(negedge clk);
    msg0_evt = m0; msg1_evt = m1; post_evt = p;
    @(negedge clk);
    msg0_evt = 1'b0; msg1_evt = 1'b0; post_evt = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1'b0, v); chk("R1 low half", v, 16'h0000);
    rd(1'b1, v); chk("R1 high half", v, 16'h0000);
    chk("R1 irq", irq, 0);
    chk("R1 mchk", mchk, 0);
  endtask

  task automatic t_msg;
    logic [15:0] v;
    pulse(1'b1, 1'b0, 1'b0);
    rd(1'b0, v); chk("R9 msg0 set", v, 16'h0001);
    chk("R11 irq from msg0", irq, 1);
    pulse(1'b0, 1'b1, 1'b0);
    rd(1'b0, v); chk("R9 msg1 set", v, 16'h0003);
    wr_lo(16'h0000);
    rd(1'b0, v); chk("R13 write zero keeps", v, 16'h0003);
    wr_lo(16'h0001);
    rd(1'b0, v); chk("R9 clear msg0 only", v, 16'h0002);
    wr_lo(16'h0002);
    rd(1'b0, v); chk("R9 clear msg1", v, 16'h0000);
    chk("R11 irq idle", irq, 0);
  endtask

  task automatic t_post;
    logic [15:0] v;
    pulse(1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R6 post set", v, 16'h0020);
    chk("R11 irq from post", irq, 1);
    chk("R5 no mchk from post", mchk, 0);
    wr_hi(16'hFFFF);
    rd(1'b0, v); chk("R2 high write ignored", v, 16'h0020);
    rd(1'b1, v); chk("R2 high reads zero", v, 16'h0000);
    wr_lo(16'hFE44);
    rd(1'b0, v); chk("R2 reserved writes ignored", v, 16'h0020);
    wr_lo(16'h0020);
    rd(1'b0, v); chk("R6 post clear", v, 16'h0000);
  endtask

  task automatic t_ovf(input bit outbound);
    logic [15:0] v;
    logic [15:0] bitv;
    string r;
    bitv = outbound ? 16'h0100 : 16'h0080;
    r = outbound ? "R4" : "R3";
    @(negedge clk);
    if (outbound) begin ofq_head = 6'd9; ofq_tail = 6'd9; ofq_full = 1'b1; end
    else          begin ipq_head = 6'd9; ipq_tail = 6'd9; ipq_full = 1'b1; end
    rd(1'b0, v); chk({r, " not yet set"}, v, 16'h0000);
    @(negedge clk);
    rd(1'b0, v); chk({r, " overflow set"}, v, bitv);
    chk("R5 mchk on overflow", mchk, 1);
    chk("R11 no irq on overflow", irq, 0);
    wr_lo(bitv);
    rd(1'b0, v); chk("R12 cleared while still full", v, 16'h0000);
    repeat (2) @(negedge clk);
    rd(1'b0, v); chk("R12 no re-set while held", v, 16'h0000);
    chk("R5 mchk drops", mchk, 0);
    if (outbound) ofq_full = 1'b0; else ipq_full = 1'b0;
    @(negedge clk);
    if (outbound) begin ofq_full = 1'b1; ofq_tail = 6'd3; end
    else          begin ipq_full = 1'b1; ipq_tail = 6'd3; end
    repeat (2) @(negedge clk);
    rd(1'b0, v); chk({r, " full but pointers differ"}, v, 16'h0000);
    if (outbound) ofq_tail = 6'd9; else ipq_tail = 6'd9;
    @(negedge clk);
    rd(1'b0, v); chk("R12 re-set on new onset", v, bitv);
    if (outbound) ofq_full = 1'b0; else ipq_full = 1'b0;
    wr_lo(bitv);
    rd(1'b0, v); chk({r, " final clear"}, v, 16'h0000);
  endtask

  task automatic t_doorbell;
    logic [15:0] v;
    @(negedge clk);
    doorbell = 32'h8000_0000;
    rd(1'b0, v); chk("R7 bit4 mirrors bit31", v, 16'h0010);
    chk("R5 mchk from doorbell", mchk, 1);
    chk("R11 no irq from bit31", irq, 0);
    wr_lo(16'h0018);
    rd(1'b0, v); chk("R7 write ignored", v, 16'h0010);
    @(negedge clk);
    doorbell = 32'h4000_0000;
    rd(1'b0, v); chk("R8 bit30 pending", v, 16'h0008);
    chk("R11 irq from doorbell", irq, 1);
    chk("R7 mchk drops with bit31", mchk, 0);
    @(negedge clk);
    doorbell = 32'h0000_0001;
    wr_lo(16'h0008);
    rd(1'b0, v); chk("R8 bit0 pending, write ignored", v, 16'h0008);
    @(negedge clk);
    doorbell = 32'h8000_0100;
    rd(1'b0, v); chk("R8 R7 both", v, 16'h0018);
    @(negedge clk);
    doorbell = '0;
    rd(1'b0, v); chk("R8 doorbell clear", v, 16'h0000);
    chk("R11 irq idle", irq, 0);
  endtask

  task automatic t_set_wins;
    logic [15:0] v;
    pulse(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    msg0_evt = 1'b1; post_evt = 1'b1;
    reg_hi = 1'b0; reg_wr = 1'b1; reg_wdata = 16'h0023;
    @(negedge clk);
    msg0_evt = 1'b0; post_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1'b0, v); chk("R10 set beats clear", v, 16'h0021);
    wr_lo(16'h01A3);
    rd(1'b0, v); chk("R10 later clear works", v, 16'h0000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    msg0_evt = 0; msg1_evt = 0; post_evt = 0;
    ipq_head = '0; ipq_tail = 6'd1; ipq_full = 0;
    ofq_head = '0; ofq_tail = 6'd1; ofq_full = 0;
    doorbell = '0; reg_hi = 0; reg_wr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_msg();
    t_post();
    t_ovf(1'b0);
    t_ovf(1'b1);
    t_doorbell();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule